// File: doc/BRIEF.md
# Ring-Buffer Stream-to-Memory DMA Channel

This block is one register-programmed DMA channel that takes words from a streaming source with a valid/ready handshake and stores them, one word per cycle, through a single-word memory write port. Software sets a start word address, a block length in words and a control word. The control word carries a run bit and a mode bit. The working address and the remaining count are only ever loaded from these programmed values. The channel never reads its parameters from memory.

There are two modes. In ring mode the channel reloads its working address and count at the end of every block, in the same cycle as the last word. It then carries on, so the buffer fills as a ring with no idle cycle at the seam. In one-shot mode it stores a single block and then goes idle until software sets the run bit again. A one-cycle interrupt pulse marks the end of every block in both modes.

Top module: `ring_dma_chan`

## Requirements
- R1: While reset is asserted, and until a run is started, `src_ready`, `mem_we` and `irq` are 0.
- R2: Register select 0 writes the start word address and select 1 writes the block length. Select 2 writes control: bit 0 is run and bit 1 is mode (1 = ring, 0 = one-shot). A control write with run = 1 while idle and with a nonzero length starts the channel at the start address in the next cycle.
- R3: A word is transferred in a cycle where `src_valid` and `src_ready` are both 1. In that same cycle `mem_we` is 1, `mem_wdata` equals `src_data` and `mem_addr` is the current word address.
- R4: The word address advances by exactly one after each transferred word that is not the last of a block.
- R5: While `mem_stall` is 1, `src_ready` is 0 and no word is written.
- R6: In ring mode the word following the last word of a block is written to the start address, and the count restarts at the programmed length. `src_ready` stays 1 across the seam, so there is no dead cycle.
- R7: `irq` is 1 for exactly the one cycle after the last word of each block, in both modes.
- R8: In one-shot mode, from the cycle after the last word, `src_ready` stays 0 and no write occurs.
- R9: Writes to the start address or the length during a ring-mode run do not disturb the block in progress. They take effect at the next reload.
- R10: A control write with run = 1 while the channel is running has no effect: the address keeps advancing and is not restarted.
- R11: A control write with run = 0 lets a word accepted in that same cycle complete. `src_ready` is 0 from the next cycle on, and no interrupt is raised.
- R12: Starting with a programmed length of zero transfers nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 start address, 1 length, 2 control |
| reg_wdata | input | RW | Register write data |
| src_valid | input | 1 | Source word available |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Channel accepts a word this cycle |
| mem_stall | input | 1 | Memory port cannot take a write this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| irq | output | 1 | One-cycle end-of-block pulse |

## Verification
The bench targets the ring seam. A wrong design would insert an idle cycle there, write the word after the last location past the buffer end, or miss or repeat the interrupt. It stalls in the middle of a block and checks that the address neither skips nor repeats. It also checks the one-shot halt: a design that reloaded in that mode would keep accepting words. Further cases are a zero length that must stay silent, a repeated run write mid-block that must not restart at the base, and a stop write that must still complete the word in flight. Finally it reprograms the base and length mid-run; a design that copied them early would corrupt the current block, and one that never copied them would wrap to the old base.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_RING_BIT = 1;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

endpackage

// File: rtl/ring_dma_cfg.sv
module ring_dma_cfg
  import ring_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [RW-1:0] reg_wdata,
  output logic [AW-1:0] prog_base,
  output logic [CW-1:0] prog_count,
  output logic          ctrl_wr,
  output logic          ctrl_run,
  output logic          ctrl_ring
);

  logic          base_ce, count_ce;
  logic [AW-1:0] base_d, base_q;
  logic [CW-1:0] count_d, count_q;

  always_comb begin
    base_ce   = reg_wr && (reg_sel == SEL_BASE);
    count_ce  = reg_wr && (reg_sel == SEL_COUNT);
    ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
    base_d    = reg_wdata[AW-1:0];
    count_d   = reg_wdata[CW-1:0];
    ctrl_run  = reg_wdata[CTRL_RUN_BIT];
    ctrl_ring = reg_wdata[CTRL_RING_BIT];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_ce) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (count_ce) begin
      count_q <= count_d;
    end
  end

  assign prog_base  = base_q;
  assign prog_count = count_q;

endmodule

// File: rtl/ring_dma_ctr.sv
module ring_dma_ctr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic          reload,
  input  logic          beat,
  input  logic [AW-1:0] prog_base,
  input  logic [CW-1:0] prog_count,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] rem_cnt,
  output logic          last
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(1);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);

  logic          ce;
  logic [AW-1:0] addr_d, addr_q;
  logic [CW-1:0] rem_d, rem_q;

  always_comb begin
    ce     = load || reload || beat;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load || reload) begin
      addr_d = prog_base;
      rem_d  = prog_count;
    end else if (beat) begin
      addr_d = addr_q + ADDR_STEP;
      rem_d  = rem_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (ce) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign cur_addr = addr_q;
  assign rem_cnt  = rem_q;
  assign last     = (rem_q == CNT_ONE);

endmodule

// File: rtl/ring_dma_fsm.sv
module ring_dma_fsm
  import ring_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic ctrl_wr,
  input  logic ctrl_run,
  input  logic ctrl_ring,
  input  logic count_nz,
  input  logic beat,
  input  logic last,
  output logic run,
  output logic ring,
  output logic load,
  output logic reload,
  output logic irq
);

  ch_state_e state_d, state_q;
  logic      ring_d, ring_q;
  logic      irq_d, irq_q;

  always_comb begin
    state_d = state_q;
    ring_d  = ring_q;
    load    = 1'b0;
    reload  = 1'b0;
    irq_d   = beat && last;
    unique case (state_q)
      CH_IDLE: begin
        if (ctrl_wr && ctrl_run && count_nz) begin
          state_d = CH_RUN;
          ring_d  = ctrl_ring;
          load    = 1'b1;
        end
      end
      CH_RUN: begin
        if (beat && last) begin
          if (ring_q) begin
            reload = 1'b1;
          end else begin
            state_d = CH_IDLE;
          end
        end
        if (ctrl_wr && !ctrl_run) begin
          state_d = CH_IDLE;
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_IDLE;
      ring_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ring_q  <= ring_d;
      irq_q   <= irq_d;
    end
  end

  assign run  = (state_q == CH_RUN);
  assign ring = ring_q;
  assign irq  = irq_q;

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [RW-1:0] reg_wdata,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  input  logic          mem_stall,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          irq
);

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [AW-1:0] prog_base;
  logic [CW-1:0] prog_count;
  logic          ctrl_wr, ctrl_run, ctrl_ring;
  logic          run_q, ring_q, load, reload;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] rem_cnt;
  logic          last, beat, count_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  ring_dma_cfg #(.AW(AW), .CW(CW), .RW(RW)) u_cfg (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .prog_base  (prog_base),
    .prog_count (prog_count),
    .ctrl_wr    (ctrl_wr),
    .ctrl_run   (ctrl_run),
    .ctrl_ring  (ctrl_ring)
  );

  ring_dma_fsm u_fsm (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .ctrl_wr   (ctrl_wr),
    .ctrl_run  (ctrl_run),
    .ctrl_ring (ctrl_ring),
    .count_nz  (count_nz),
    .beat      (beat),
    .last      (last),
    .run       (run_q),
    .ring      (ring_q),
    .load      (load),
    .reload    (reload),
    .irq       (irq)
  );

  ring_dma_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .load       (load),
    .reload     (reload),
    .beat       (beat),
    .prog_base  (prog_base),
    .prog_count (prog_count),
    .cur_addr   (cur_addr),
    .rem_cnt    (rem_cnt),
    .last       (last)
  );

  assign count_nz  = |prog_count;
  assign src_ready = run_q && !mem_stall;
  assign beat      = src_valid && src_ready;
  assign mem_we    = beat;
  assign mem_addr  = cur_addr;
  assign mem_wdata = src_data;

endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic [RW-1:0] reg_wdata,
  input logic          src_ready,
  input logic          mem_stall,
  input logic          mem_we,
  input logic          irq,
  input logic          run_q,
  input logic          ring_q,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] rem_cnt,
  input logic [AW-1:0] prog_base,
  input logic [CW-1:0] prog_count
);

  logic at_end;
  logic ctrl_w;
  assign at_end = mem_we && (rem_cnt == CW'(1));
  assign ctrl_w = reg_wr && (reg_sel == 2'd2);

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_stall |-> !src_ready); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_we && !at_end) |=> (cur_addr == $past(cur_addr) + AW'(1))); // R4

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (at_end && ring_q && !reg_wr) |=> (run_q && cur_addr == prog_base && rem_cnt == prog_count)); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> $past(at_end)); // R7

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_ni)
    (at_end && !ring_q) |=> !src_ready); // R8

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && ctrl_w && reg_wdata[0] && prog_count == '0) |=> (!src_ready && !irq)); // R12

  AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_w && !reg_wdata[0]) |=> !src_ready); // R11

endmodule

bind ring_dma_chan ring_dma_chk #(.AW(AW), .CW(CW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .src_ready  (src_ready),
  .mem_stall  (mem_stall),
  .mem_we     (mem_we),
  .irq        (irq),
  .run_q      (run_q),
  .ring_q     (ring_q),
  .cur_addr   (cur_addr),
  .rem_cnt    (rem_cnt),
  .prog_base  (prog_base),
  .prog_count (prog_count)
);

// File: tb/ring_dma_chan_bench.sv
module ring_dma_chan_bench;

  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;
  localparam int AW = 16, CW = 16, DW = 32, RW = 32;
  localparam int NVEC = 10;

  // {valid, stall, exp_ready, exp_we, exp_irq, exp_addr}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0040},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0041},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0041},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0041},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0042},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0040},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0041},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0042},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0040},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0040}
  };

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_sel;
  logic [RW-1:0] reg_wdata;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          src_ready;
  logic          mem_stall;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          irq;

  int nchk = 0;
  int nerr = 0;

  ring_dma_chan #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) u_ring_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .mem_stall(mem_stall), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // drive one cycle's inputs after the falling edge, return just before the rising edge
  task automatic cyc(input logic v, input logic st, input logic [31:0] d,
                     input logic wr, input logic [1:0] sel, input logic [31:0] wd);
    @(negedge clk);
    src_valid = v; mem_stall = st; src_data = d;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    #(HALF - 1);
  endtask

  task automatic prog(input logic [1:0] sel, input logic [31:0] wd);
    cyc(1'b0, 1'b0, 32'h0, 1'b1, sel, wd);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    src_valid = 1'b1; src_data = '0; mem_stall = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'b0, src_ready}, 32'd0);
    chk("R1 reset we",    {31'b0, mem_we},    32'd0);
    chk("R1 reset irq",   {31'b0, irq},       32'd0);
    rst_n = 1'b1;
    src_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle ready", {31'b0, src_ready}, 32'd0);

    // ring run: base 0x40, length 3
    prog(2'd0, 32'h40);
    prog(2'd1, 32'd3);
    prog(2'd2, 32'h3);
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][20], VEC[i][19], 32'hA000 + i, 1'b0, 2'd0, 32'h0);
      chk($sformatf("R5 ready v%0d", i), {31'b0, src_ready}, {31'b0, VEC[i][18]});
      chk($sformatf("R3 we v%0d", i),    {31'b0, mem_we},    {31'b0, VEC[i][17]});
      chk($sformatf("R7 irq v%0d", i),   {31'b0, irq},       {31'b0, VEC[i][16]});
      chk($sformatf("R6 addr v%0d", i),  {16'b0, mem_addr},  {16'b0, VEC[i][15:0]});
      if (VEC[i][17]) chk($sformatf("R3 data v%0d", i), mem_wdata, 32'hA000 + i);
    end
    prog(2'd2, 32'h0);

    // R12: zero length
    prog(2'd1, 32'd0);
    prog(2'd2, 32'h1);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 1'b0, 32'h0, 1'b0, 2'd0, 32'h0);
      chk("R12 zero ready", {31'b0, src_ready}, 32'd0);
      chk("R12 zero irq",   {31'b0, irq},       32'd0);
    end

    // R2/R8: one-shot, base 0x10, length 2
    prog(2'd0, 32'h10);
    prog(2'd1, 32'd2);
    prog(2'd2, 32'h1);
    cyc(1'b1, 1'b0, 32'hB0, 1'b0, 2'd0, 32'h0);
    chk("R2 start addr", {16'b0, mem_addr}, 32'h10);
    chk("R2 start we",   {31'b0, mem_we},   32'd1);
    cyc(1'b1, 1'b0, 32'hB1, 1'b0, 2'd0, 32'h0);
    chk("R4 step addr", {16'b0, mem_addr}, 32'h11);
    cyc(1'b1, 1'b0, 32'hB2, 1'b0, 2'd0, 32'h0);
    chk("R7 oneshot irq",   {31'b0, irq},       32'd1);
    chk("R8 oneshot ready", {31'b0, src_ready}, 32'd0);
    chk("R8 oneshot we",    {31'b0, mem_we},    32'd0);
    cyc(1'b1, 1'b0, 32'hB3, 1'b0, 2'd0, 32'h0);
    chk("R7 irq single",   {31'b0, irq},       32'd0);
    chk("R8 still halted", {31'b0, src_ready}, 32'd0);

    // R11: stop write with a word in flight
    prog(2'd2, 32'h1);
    cyc(1'b1, 1'b0, 32'hC0, 1'b1, 2'd2, 32'h0);
    chk("R11 inflight we",   {31'b0, mem_we},   32'd1);
    chk("R11 inflight addr", {16'b0, mem_addr}, 32'h10);
    cyc(1'b1, 1'b0, 32'hC1, 1'b0, 2'd0, 32'h0);
    chk("R11 stopped ready", {31'b0, src_ready}, 32'd0);
    chk("R11 no irq",        {31'b0, irq},       32'd0);

    // R10/R9: ring base 0x20 length 4, re-run mid block, reprogram mid run
    prog(2'd0, 32'h20);
    prog(2'd1, 32'd4);
    prog(2'd2, 32'h3);
    cyc(1'b1, 1'b0, 32'hD0, 1'b0, 2'd0, 32'h0);
    chk("R10 first addr", {16'b0, mem_addr}, 32'h20);
    cyc(1'b0, 1'b0, 32'h0, 1'b1, 2'd2, 32'h3);
    cyc(1'b1, 1'b0, 32'hD1, 1'b0, 2'd0, 32'h0);
    chk("R10 no restart", {16'b0, mem_addr}, 32'h21);
    prog(2'd0, 32'h30);
    prog(2'd1, 32'd2);
    cyc(1'b1, 1'b0, 32'hD2, 1'b0, 2'd0, 32'h0);
    chk("R9 block kept", {16'b0, mem_addr}, 32'h22);
    cyc(1'b1, 1'b0, 32'hD3, 1'b0, 2'd0, 32'h0);
    chk("R9 block kept end", {16'b0, mem_addr}, 32'h23);
    cyc(1'b1, 1'b0, 32'hD4, 1'b0, 2'd0, 32'h0);
    chk("R9 new base", {16'b0, mem_addr}, 32'h30);
    chk("R6 seam we",  {31'b0, mem_we},   32'd1);
    chk("R7 seam irq", {31'b0, irq},      32'd1);
    cyc(1'b1, 1'b0, 32'hD5, 1'b0, 2'd0, 32'h0);
    chk("R9 new addr", {16'b0, mem_addr}, 32'h31);
    chk("R7 irq low",  {31'b0, irq},      32'd0);
    cyc(1'b1, 1'b0, 32'hD6, 1'b0, 2'd0, 32'h0);
    chk("R9 new length wrap", {16'b0, mem_addr}, 32'h30);
    chk("R7 short block irq", {31'b0, irq},      32'd1);

    prog(2'd2, 32'h0);
    finish_run();
  end

endmodule